// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block owns a configurable number of general-purpose pins and presents them to software as five register regions. For every pin it holds an output value, a direction, a choice between plain GPIO use and a peripheral function, and a pull-resistor enable with its polarity. It also brings the pad input level back through a two-flop synchroniser, so software can read the level. Each 32-bit register word serves sixteen pins.

The output-value region takes masked writes. The upper half of the written word selects which pins in the lower half are updated. Software can therefore set or clear one pin in a single write, with no read-modify-write. The other four regions take plain writes of the lower half. Pins handed to the peripheral function take their pad value and pad output enable from the peripheral's own per-pin lines.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Pin n sits in the word at byte offset (n/16)*4 inside each region, at bit n%16. The regions start at 0x000 (output value / input level), 0x100 (direction), 0x200 (function select), 0x300 (pull enable) and 0x400 (pull polarity). Address bits [10:8] pick the region and bits [7:2] pick the word.
- R2: On a write to the output-value region, lower bit i of the word changes to the written bit i only when bit i+16 of the written word is 1. A write with an all-zero upper half changes nothing.
- R3: A read of the output-value region returns the synchronised pad input levels in bits 15:0 and zero in bits 31:16. Read data appears on bus_rdata in the cycle after the request. A change on pad_in reaches the readable level after two clock edges.
- R4: For a pin whose function-select bit is 0, pad_out equals the pin's output value. pad_oe equals its direction bit, where 1 means output and 0 means input.
- R5: For a pin whose function-select bit is 1, pad_out follows periph_out and pad_oe follows periph_oe. periph_sel shows the function-select bit.
- R6: pull_en shows the pull-enable bit (1 = resistor on). pull_up shows the polarity bit (1 = pull-up, 0 = pull-down).
- R7: After reset every pin is a GPIO input with its output value at 0 and pulls off. bus_rdata is 0.
- R8: The direction, function-select, pull-enable and pull-polarity regions take bits 15:0 of a write as they are and ignore bits 31:16. A read of these regions returns the stored bits in 15:0 and zero in 31:16.
- R9: An access changes no state and reads as zero when any of these holds: the address is unaligned, it names a region above 0x400, or it names a word beyond the last populated one. Bits for pin positions at or beyond NUM_PINS always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pad_in | input | NUM_PINS | Raw pad input levels |
| periph_out | input | NUM_PINS | Peripheral output value per pin |
| periph_oe | input | NUM_PINS | Peripheral output enable per pin |
| pad_out | output | NUM_PINS | Value driven to the pad |
| pad_oe | output | NUM_PINS | Pad output enable |
| periph_sel | output | NUM_PINS | 1 where the pin is given to the peripheral |
| pull_en | output | NUM_PINS | Pull resistor enable |
| pull_up | output | NUM_PINS | Pull polarity, 1 = up |

## Verification
The bench builds the controller with NUM_PINS = 40 and leaves ADDR_W at its default. The third word is then only half populated, so the masking of absent pin positions can be seen on both the outputs and readback. A word index of 3 falls past the last word and checks the out-of-range decode, which the default 208-pin build would only hit at index 13. With the small pin count, every pin output can be compared as a whole vector after each write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PINS_PER_WORD = 16;

    // Register region, decoded from address bits [10:8]
    typedef enum logic [2:0] {
        RG_DATA = 3'd0,
        RG_DIR  = 3'd1,
        RG_FSEL = 3'd2,
        RG_PEN  = 3'd3,
        RG_PUP  = 3'd4
    } region_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stable;

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int NUM_PINS = 16
) (
    input  logic [NUM_PINS-1:0] gpio_val,
    input  logic [NUM_PINS-1:0] gpio_dir,
    input  logic [NUM_PINS-1:0] func_sel,
    input  logic [NUM_PINS-1:0] periph_out,
    input  logic [NUM_PINS-1:0] periph_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_comb begin
            pad_out[p] = func_sel[p] ? periph_out[p] : gpio_val[p];
            pad_oe[p]  = func_sel[p] ? periph_oe[p]  : gpio_dir[p];
        end
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 208,
    parameter int ADDR_W   = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] periph_out,
    input  logic [NUM_PINS-1:0] periph_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] periph_sel,
    output logic [NUM_PINS-1:0] pull_en,
    output logic [NUM_PINS-1:0] pull_up
);

    // Word index is address bits [7:2]: at most 64 words (1024 pins).
    localparam int NWORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
    localparam int PAD_W  = NWORDS * PINS_PER_WORD;
    localparam int IDX_W  = 6;
    localparam int RGN_W  = ADDR_W - 8;

    function automatic logic [PAD_W-1:0] pin_mask();
        logic [PAD_W-1:0] m;
        for (int i = 0; i < PAD_W; i++) m[i] = (i < NUM_PINS);
        return m;
    endfunction

    localparam logic [PAD_W-1:0] VALID = pin_mask();

    typedef struct packed {
        logic [PAD_W-1:0] dout;
        logic [PAD_W-1:0] dir;
        logic [PAD_W-1:0] fsel;
        logic [PAD_W-1:0] pen;
        logic [PAD_W-1:0] pup;
        logic [31:0]      rdata;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_PINS-1:0] pad_sync;
    logic [PAD_W-1:0]    sync_ext;
    logic [RGN_W-1:0]    region_raw;
    region_e             region;
    logic [IDX_W-1:0]    widx;
    logic                acc_hit;
    logic                acc_wr;
    logic                acc_rd;
    logic                wr_data_hit;

    gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    assign sync_ext   = PAD_W'(pad_sync) & VALID;
    assign region_raw = bus_addr[ADDR_W-1:8];
    assign region     = region_e'(region_raw[2:0]);
    assign widx       = bus_addr[7:2];
    assign acc_hit    = (region_raw <= RGN_W'(4)) && (bus_addr[1:0] == 2'b00)
                        && (widx < IDX_W'(NWORDS));
    assign acc_wr     = bus_en && bus_we && acc_hit;
    assign acc_rd     = bus_en && !bus_we && acc_hit;
    assign wr_data_hit = acc_wr && (region == RG_DATA);

    always_comb begin
        s_d       = s_q;
        s_d.rdata = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (widx == IDX_W'(w)) begin
                if (acc_wr) begin
                    case (region)
                        RG_DATA: begin
                            for (int b = 0; b < PINS_PER_WORD; b++) begin
                                if (bus_wdata[PINS_PER_WORD+b])
                                    s_d.dout[w*PINS_PER_WORD+b] = bus_wdata[b];
                            end
                        end
                        RG_DIR:  s_d.dir[w*PINS_PER_WORD +: PINS_PER_WORD]  = bus_wdata[15:0];
                        RG_FSEL: s_d.fsel[w*PINS_PER_WORD +: PINS_PER_WORD] = bus_wdata[15:0];
                        RG_PEN:  s_d.pen[w*PINS_PER_WORD +: PINS_PER_WORD]  = bus_wdata[15:0];
                        RG_PUP:  s_d.pup[w*PINS_PER_WORD +: PINS_PER_WORD]  = bus_wdata[15:0];
                        default: ;
                    endcase
                end
                if (acc_rd) begin
                    case (region)
                        RG_DATA: s_d.rdata[15:0] = sync_ext[w*PINS_PER_WORD +: PINS_PER_WORD];
                        RG_DIR:  s_d.rdata[15:0] = s_q.dir[w*PINS_PER_WORD +: PINS_PER_WORD];
                        RG_FSEL: s_d.rdata[15:0] = s_q.fsel[w*PINS_PER_WORD +: PINS_PER_WORD];
                        RG_PEN:  s_d.rdata[15:0] = s_q.pen[w*PINS_PER_WORD +: PINS_PER_WORD];
                        RG_PUP:  s_d.rdata[15:0] = s_q.pup[w*PINS_PER_WORD +: PINS_PER_WORD];
                        default: ;
                    endcase
                end
            end
        end
        // Positions beyond the pin count never hold a 1
        s_d.dout = s_d.dout & VALID;
        s_d.dir  = s_d.dir  & VALID;
        s_d.fsel = s_d.fsel & VALID;
        s_d.pen  = s_d.pen  & VALID;
        s_d.pup  = s_d.pup  & VALID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    gpio_pad_mux #(.NUM_PINS(NUM_PINS)) u_mux (
        .gpio_val   (s_q.dout[NUM_PINS-1:0]),
        .gpio_dir   (s_q.dir[NUM_PINS-1:0]),
        .func_sel   (s_q.fsel[NUM_PINS-1:0]),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    assign periph_sel = s_q.fsel[NUM_PINS-1:0];
    assign pull_en    = s_q.pen[NUM_PINS-1:0];
    assign pull_up    = s_q.pup[NUM_PINS-1:0];
    assign bus_rdata  = s_q.rdata;

    // R2: unselected bits of word 0 keep their value
    a_r2_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_hit && widx == '0) |=>
        (((s_q.dout[15:0] ^ $past(s_q.dout[15:0])) & ~$past(bus_wdata[31:16])) == 16'h0));

    // R2: selected bits of word 0 take the written value
    a_r2_mask_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_hit && widx == '0) |=>
        (((s_q.dout[15:0] ^ $past(bus_wdata[15:0])) & $past(bus_wdata[31:16])
          & VALID[15:0]) == 16'h0));

    // R3, R8: upper half of any read is zero
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we) |=> (bus_rdata[31:16] == 16'h0));

    // R9: a missed access reads zero
    a_r9_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && !acc_hit) |=> (bus_rdata == 32'h0));

    // R9: without a decoded write no register changes
    a_r9_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |=> ($stable(s_q.dout) && $stable(s_q.dir) && $stable(s_q.fsel)
                     && $stable(s_q.pen) && $stable(s_q.pup)));

endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 40;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  periph_out = '0;
    logic [N-1:0]  periph_oe = '0;
    logic [N-1:0]  pad_out, pad_oe, periph_sel, pull_en, pull_up;

    int checks = 0;
    int errors = 0;

    // Reference model of the stored state, updated from the requirements
    logic [47:0] m_dout = '0, m_dir = '0, m_fsel = '0, m_pen = '0, m_pup = '0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_ctrl #(.NUM_PINS(N), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .periph_out(periph_out), .periph_oe(periph_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .periph_sel(periph_sel),
        .pull_en(pull_en), .pull_up(pull_up)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: note a read at the edge, compare away from it
    always @(posedge clk) rd_seen <= bus_en && !bus_we;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R3 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    function automatic bit decoded(logic [AW-1:0] a);
        return (a[AW-1:8] <= 3'd4) && (a[1:0] == 2'b00) && (a[7:2] < 6'd3);
    endfunction

    task automatic model_write(logic [AW-1:0] a, logic [31:0] d);
        int base;
        if (!decoded(a)) return;
        base = int'(a[7:2]) * 16;
        for (int b = 0; b < 16; b++) begin
            if (base + b < N) begin
                case (a[10:8])
                    3'd0: if (d[16+b]) m_dout[base+b] = d[b];
                    3'd1: m_dir[base+b]  = d[b];
                    3'd2: m_fsel[base+b] = d[b];
                    3'd3: m_pen[base+b]  = d[b];
                    3'd4: m_pup[base+b]  = d[b];
                    default: ;
                endcase
            end
        end
    endtask

    function automatic logic [31:0] model_read(logic [AW-1:0] a);
        logic [47:0] src;
        logic [47:0] pin_ext;
        if (!decoded(a)) return 32'h0;
        pin_ext = 48'(pad_in);
        case (a[10:8])
            3'd0: src = pin_ext;
            3'd1: src = m_dir;
            3'd2: src = m_fsel;
            3'd3: src = m_pen;
            default: src = m_pup;
        endcase
        return {16'h0, src[int'(a[7:2])*16 +: 16]};
    endfunction

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        model_write(a, d);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, string tag);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic check_pins(string tag);
        logic [N-1:0] e_out, e_oe;
        for (int p = 0; p < N; p++) begin
            e_out[p] = m_fsel[p] ? periph_out[p] : m_dout[p];
            e_oe[p]  = m_fsel[p] ? periph_oe[p]  : m_dir[p];
        end
        check({tag, " pad_out"},    64'(pad_out),    64'(e_out));
        check({tag, " pad_oe"},     64'(pad_oe),     64'(e_oe));
        check({tag, " periph_sel"}, 64'(periph_sel), 64'(m_fsel[N-1:0]));
        check({tag, " pull_en"},    64'(pull_en),    64'(m_pen[N-1:0]));
        check({tag, " pull_up"},    64'(pull_up),    64'(m_pup[N-1:0]));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state
        check_pins("R7 reset");
        check("R7 rdata reset", 64'(bus_rdata), 64'h0);
        bus_read(11'h100, "R7 dir readback after reset");

        // R2/R4: masked writes to the output value of word 0
        bus_write(11'h000, 32'hFFFF_A5A5);
        bus_write(11'h100, 32'h0000_FFFF);
        check_pins("R4 gpio output word0");
        bus_write(11'h000, 32'h0001_0000);
        check("R2 clear bit0", 64'(pad_out[15:0]), 64'hA5A4);
        bus_write(11'h000, 32'h0200_FFFF);
        check("R2 set bit9", 64'(pad_out[15:0]), 64'hA7A4);
        bus_write(11'h000, 32'h0000_FFFF);
        check("R2 zero mask no change", 64'(pad_out[15:0]), 64'hA7A4);
        check_pins("R2 after masked writes");

        // R1: other words and bit positions
        bus_write(11'h004, 32'hFFFF_1234);
        bus_write(11'h008, 32'hFFFF_FFFF);
        bus_write(11'h108, 32'h0000_0020);
        check("R1 pin37 direction", 64'(pad_oe[39:32]), 64'h20);
        check_pins("R1 words 1 and 2");

        // R3: synchronised input readback
        pad_in = 40'hAB_CDEF_1234;
        repeat (3) @(negedge clk);
        bus_read(11'h000, "R3 input word0");
        bus_read(11'h004, "R3 input word1");
        bus_read(11'h008, "R3 input word2");
        pad_in = 40'h54_3210_FEDC;
        repeat (3) @(negedge clk);
        bus_read(11'h004, "R3 input word1 changed");

        // R8: plain writes, upper half ignored
        bus_write(11'h100, 32'hFFFF_0F0F);
        bus_read(11'h100, "R8 dir upper ignored");
        check_pins("R8 dir word0");

        // R5: peripheral ownership
        periph_out = '1;
        periph_oe  = 40'h00_0000_0030;
        bus_write(11'h200, 32'h0000_00F0);
        check_pins("R5 peripheral pins");
        check("R5 pad_oe nibble", 64'(pad_oe[7:4]), 64'h3);
        bus_read(11'h200, "R5 fsel readback");

        // R6: pull controls
        bus_write(11'h304, 32'h0000_00FF);
        bus_write(11'h404, 32'hFFFF_000F);
        check_pins("R6 pulls");
        bus_read(11'h304, "R6 pull enable readback");
        bus_read(11'h404, "R6 pull polarity readback");

        // R9: undecoded accesses and absent pins
        bus_write(11'h500, 32'hFFFF_FFFF);
        bus_write(11'h10C, 32'hFFFF_FFFF);
        bus_write(11'h101, 32'hFFFF_FFFF);
        check_pins("R9 misses change nothing");
        bus_read(11'h500, "R9 region miss reads zero");
        bus_read(11'h10C, "R9 word miss reads zero");
        bus_write(11'h108, 32'h0000_FFFF);
        bus_read(11'h108, "R9 absent pins read zero");
        check_pins("R9 partial word");

        repeat (3) @(negedge clk);
        check("R3 all reads returned", 64'(exp_q.size()), 64'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule